// File: doc/BRIEF.md
# Pushbutton Step Generator with Debounce and Auto-Repeat

This block turns raw, bouncy pushbutton levels for one adjustment channel into clean step commands. Each command is a single-cycle strobe with a direction bit that says whether the downstream value should go up or down. Two request levels come in: one asks for increment and one asks for decrement. Together they stand for a button input that is pulled high, pulled low or left open. A slow timebase tick in the 1 kHz class paces all the timing, so the debounce, hold and repeat intervals are counted in ticks and not in clock cycles.

A request is accepted only after it has stayed unchanged for a settle interval. Acceptance gives one step at once. If the button is still held after a long hold interval, steps follow at a fixed repeat rate until the button is let go. Any change of the request restarts the whole sequence: a release, a reversal, a bounce or both requests at once. A sleep input keeps the block quiet. The block is used only when the channel is in button mode. In pulse mode the step source bypasses it.

Top module: `btn_repeat`

## Requirements
- R1: After reset, `stepValid` is 0 and the block is idle until a request is seen.
- R2: A step raised by the increment request has `stepUp` = 1. A step raised by the decrement request has `stepUp` = 0.
- R3: The first step of a press appears in the cycle after the DEBOUNCE_TICKS-th tick counted since the request last changed. Every step strobe lies in the cycle after a tick.
- R4: After the first step, no further step is issued until HOLD_TICKS more ticks have been counted while the request stays unchanged. The step on that tick is the second step.
- R5: After the second step, a step is issued every RATE_TICKS ticks while the request stays unchanged.
- R6: Any change of the request cancels pending and repeating steps and restarts the settle count: a release, a bounce shorter than the settle interval, or a reversal of direction. A new press is debounced again from zero.
- R7: Both requests active at once count as no request, and no step is issued.
- R8: While `sleepEn` is 1 no step is issued and all timers are cleared. If a press is still held when sleep ends, it is debounced again from zero.
- R9: `stepValid` is high for exactly one clock cycle per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle timebase tick that paces all intervals |
| sleepEn | input | 1 | Sleep: clears timers and blocks steps while 1 |
| upReq | input | 1 | Raw increment request level |
| downReq | input | 1 | Raw decrement request level |
| stepValid | output | 1 | One-cycle step strobe |
| stepUp | output | 1 | Step direction, 1 = increment, valid with stepValid |

## Verification
The bench builds the block with a settle of 3 ticks, a hold of 8 ticks and a repeat period of 2 ticks, and it drives a tick every fourth clock. With these values a tap, a hold that runs into several repeats, a bounce, a reversal while repeating, and a sleep window each fit in a few dozen ticks. The tick index at which every strobe appears can therefore be predicted and compared exactly. The spacing between ticks also shows whether any strobe is wider than one cycle.

// File: rtl/btn_repeat_pkg.sv
package btn_repeat_pkg;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_UP   = 2'd1,
    REQ_DOWN = 2'd2
  } req_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2,
    ST_REPEAT = 2'd3
  } state_e;

  typedef enum logic [1:0] {
    LIM_SETTLE = 2'd0,
    LIM_HOLD   = 2'd1,
    LIM_RATE   = 2'd2
  } lim_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    lim_e limSel;
    logic fire;
  } ctrl_s;

endpackage

// File: rtl/btn_repeat_dp.sv
module btn_repeat_dp
  import btn_repeat_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 13,
  parameter int HOLD_TICKS     = 410,
  parameter int RATE_TICKS     = 47
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  tickEn,
  input  logic  upReq,
  input  logic  downReq,
  input  ctrl_s ctrl,
  output req_e  reqNow,
  output logic  limitHit,
  output logic  stepValid,
  output logic  stepUp
);

  localparam int MAX_A  = (DEBOUNCE_TICKS > HOLD_TICKS) ? DEBOUNCE_TICKS : HOLD_TICKS;
  localparam int MAX_T  = (MAX_A > RATE_TICKS) ? MAX_A : RATE_TICKS;
  localparam int CW     = (MAX_T < 2) ? 1 : $clog2(MAX_T);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(DEBOUNCE_TICKS - 1);
  localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] RATE_LAST   = CW'(RATE_TICKS - 1);

  logic [CW-1:0] tickCnt;
  logic [CW-1:0] curLast;
  req_e          reqDec;

  // decode the two request levels; both at once counts as none
  always_comb begin
    unique case ({upReq, downReq})
      2'b10:   reqDec = REQ_UP;
      2'b01:   reqDec = REQ_DOWN;
      default: reqDec = REQ_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqNow <= REQ_NONE;
    else       reqNow <= reqDec;
  end

  always_comb begin
    unique case (ctrl.limSel)
      LIM_HOLD: curLast = HOLD_LAST;
      LIM_RATE: curLast = RATE_LAST;
      default:  curLast = SETTLE_LAST;
    endcase
  end

  assign limitHit = (tickCnt == curLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tickCnt <= '0;
    else if (ctrl.cntClr)  tickCnt <= '0;
    else if (ctrl.cntInc)  tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepValid <= 1'b0;
      stepUp    <= 1'b0;
    end else begin
      stepValid <= ctrl.fire;
      if (ctrl.fire) stepUp <= (reqNow == REQ_UP);
    end
  end

  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |-> $past(tickEn)) else $error("step without tick"); // R3

  AST_STEP_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |-> $past(reqNow != REQ_NONE)) else $error("step with no request"); // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cntInc |-> !limitHit) else $error("counter passed limit"); // R5

endmodule

// File: rtl/btn_repeat_ctrl.sv
module btn_repeat_ctrl
  import btn_repeat_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  sleepEn,
  input  logic  tickEn,
  input  req_e  reqNow,
  input  logic  limitHit,
  output ctrl_s ctrl
);

  state_e state, stateNxt;
  req_e   heldReq, heldNxt;

  always_comb begin
    stateNxt    = state;
    heldNxt     = heldReq;
    ctrl        = '0;
    unique case (state)
      ST_HELD:   ctrl.limSel = LIM_HOLD;
      ST_REPEAT: ctrl.limSel = LIM_RATE;
      default:   ctrl.limSel = LIM_SETTLE;
    endcase
    if (sleepEn) begin
      stateNxt    = ST_IDLE;
      heldNxt     = REQ_NONE;
      ctrl.cntClr = 1'b1;
    end else if (reqNow != heldReq) begin
      heldNxt     = reqNow;
      ctrl.cntClr = 1'b1;
      stateNxt    = (reqNow == REQ_NONE) ? ST_IDLE : ST_SETTLE;
    end else if (state != ST_IDLE && tickEn) begin
      if (limitHit) begin
        ctrl.fire   = 1'b1;
        ctrl.cntClr = 1'b1;
        stateNxt    = (state == ST_SETTLE) ? ST_HELD : ST_REPEAT;
      end else begin
        ctrl.cntInc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      heldReq <= REQ_NONE;
    end else begin
      state   <= stateNxt;
      heldReq <= heldNxt;
    end
  end

  AST_NONE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqNow == REQ_NONE) |=> (state == ST_IDLE)) else $error("active without request"); // R7

  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    sleepEn |=> (state == ST_IDLE && heldReq == REQ_NONE)) else $error("sleep not idle"); // R8

  AST_NO_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !ctrl.fire) else $error("fire while idle"); // R6

endmodule

// File: rtl/btn_repeat.sv
module btn_repeat
  import btn_repeat_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 13,
  parameter int HOLD_TICKS     = 410,
  parameter int RATE_TICKS     = 47
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic sleepEn,
  input  logic upReq,
  input  logic downReq,
  output logic stepValid,
  output logic stepUp
);

  ctrl_s ctrl;
  req_e  reqNow;
  logic  limitHit;

  btn_repeat_dp #(
    .DEBOUNCE_TICKS(DEBOUNCE_TICKS),
    .HOLD_TICKS    (HOLD_TICKS),
    .RATE_TICKS    (RATE_TICKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .upReq    (upReq),
    .downReq  (downReq),
    .ctrl     (ctrl),
    .reqNow   (reqNow),
    .limitHit (limitHit),
    .stepValid(stepValid),
    .stepUp   (stepUp)
  );

  btn_repeat_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sleepEn (sleepEn),
    .tickEn  (tickEn),
    .reqNow  (reqNow),
    .limitHit(limitHit),
    .ctrl    (ctrl)
  );

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    sleepEn |=> !stepValid) else $error("step during sleep"); // R8

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |=> !stepValid) else $error("strobe too wide"); // R9

endmodule

// File: tb/btn_repeat_tb.sv
`timescale 1ns/1ps
module btn_repeat_tb;

  localparam int DEB  = 3;
  localparam int HOLD = 8;
  localparam int RATE = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic sleepEn = 1'b0;
  logic upReq = 1'b0;
  logic downReq = 1'b0;
  logic stepValid, stepUp;

  int checks = 0;
  int fails = 0;
  int tickSeen = 0;
  int nHits = 0;
  int hitTick [256];
  bit hitUp [256];
  int wideCount = 0;
  bit prevValid = 1'b0;

  always #5 clk = ~clk;

  btn_repeat #(.DEBOUNCE_TICKS(DEB), .HOLD_TICKS(HOLD), .RATE_TICKS(RATE)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sleepEn(sleepEn),
    .upReq(upReq), .downReq(downReq), .stepValid(stepValid), .stepUp(stepUp)
  );

  // timebase: one-cycle tick every fourth clock
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tickEn <= 1'b1;
      @(negedge clk);
      tickEn <= 1'b0;
    end
  end

  always @(posedge clk) if (tickEn) tickSeen <= tickSeen + 1;

  // strobe recorder
  initial begin
    forever begin
      @(negedge clk);
      if (stepValid && prevValid) wideCount++;
      prevValid = stepValid;
      if (stepValid && nHits < 256) begin
        hitTick[nHits] = tickSeen;
        hitUp[nHits]   = stepUp;
        nHits++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic syncTick(output int t);
    @(posedge clk iff tickEn);
    @(negedge clk);
    t = tickSeen;
  endtask

  task automatic waitTicks(input int n);
    int t;
    for (int i = 0; i < n; i++) syncTick(t);
  endtask

  task automatic checkHit(input int idx, input int expTick, input bit expUp, input string req);
    check(hitTick[idx] == expTick, req, hitTick[idx], expTick);
    check(hitUp[idx] == expUp, {req, " dir"}, int'(hitUp[idx]), int'(expUp));
  endtask

  task automatic testReset();
    repeat (6) @(negedge clk);
    check(stepValid == 1'b0, "R1 reset strobe", int'(stepValid), 0);
    check(nHits == 0, "R1 reset hits", nHits, 0);
  endtask

  task automatic testTap();
    int t0, base;
    base = nHits;
    syncTick(t0);
    upReq = 1'b1;
    waitTicks(DEB + 2);
    upReq = 1'b0;
    waitTicks(HOLD + 4);
    check(nHits - base == 1, "R3/R4 tap count", nHits - base, 1);
    checkHit(base, t0 + DEB, 1'b1, "R3 tap tick R2");
  endtask

  task automatic testLongHold();
    int t0, base;
    base = nHits;
    syncTick(t0);
    downReq = 1'b1;
    waitTicks(DEB + HOLD + 2 * RATE);
    downReq = 1'b0;
    waitTicks(HOLD + 4);
    check(nHits - base == 4, "R5 hold count", nHits - base, 4);
    checkHit(base,     t0 + DEB,                   1'b0, "R3 hold first R2");
    checkHit(base + 1, t0 + DEB + HOLD,            1'b0, "R4 hold second");
    checkHit(base + 2, t0 + DEB + HOLD + RATE,     1'b0, "R5 repeat one");
    checkHit(base + 3, t0 + DEB + HOLD + 2 * RATE, 1'b0, "R5 repeat two");
  endtask

  task automatic testBounce();
    int t0, t2, base;
    base = nHits;
    syncTick(t0);
    upReq = 1'b1;
    waitTicks(1);
    upReq = 1'b0;
    waitTicks(1);
    upReq = 1'b1;
    waitTicks(DEB - 1);
    upReq = 1'b0;
    syncTick(t2);
    upReq = 1'b1;
    waitTicks(DEB + 1);
    upReq = 1'b0;
    waitTicks(HOLD + 4);
    check(nHits - base == 1, "R6 bounce count", nHits - base, 1);
    checkHit(base, t2 + DEB, 1'b1, "R6 bounce tick");
  endtask

  task automatic testBoth();
    int base;
    base = nHits;
    waitTicks(1);
    upReq = 1'b1;
    downReq = 1'b1;
    waitTicks(DEB + HOLD + 2);
    upReq = 1'b0;
    downReq = 1'b0;
    waitTicks(4);
    check(nHits - base == 0, "R7 both idle", nHits - base, 0);
  endtask

  task automatic testReverse();
    int t0, t2, base;
    base = nHits;
    syncTick(t0);
    upReq = 1'b1;
    waitTicks(DEB + HOLD + RATE);
    upReq = 1'b0;
    downReq = 1'b1;
    t2 = tickSeen;
    waitTicks(DEB + 1);
    downReq = 1'b0;
    waitTicks(HOLD + 4);
    check(nHits - base == 4, "R6 reverse count", nHits - base, 4);
    checkHit(base + 2, t0 + DEB + HOLD + RATE, 1'b1, "R5 reverse repeat");
    checkHit(base + 3, t2 + DEB, 1'b0, "R6 reverse redebounce R2");
  endtask

  task automatic testSleep();
    int t3, base;
    base = nHits;
    waitTicks(1);
    sleepEn = 1'b1;
    upReq = 1'b1;
    waitTicks(DEB + HOLD + 2);
    check(nHits - base == 0, "R8 sleep quiet", nHits - base, 0);
    syncTick(t3);
    sleepEn = 1'b0;
    waitTicks(DEB + 1);
    upReq = 1'b0;
    waitTicks(HOLD + 4);
    check(nHits - base == 1, "R8 wake count", nHits - base, 1);
    checkHit(base, t3 + DEB, 1'b1, "R8 wake tick");
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTap();
    testLongHold();
    testBounce();
    testBoth();
    testReverse();
    testSleep();
    check(wideCount == 0, "R9 strobe width", wideCount, 0);
    finishRun();
  end

endmodule